// File: doc/BRIEF.md
# Internal Data Memory with Register Banks and Bit Access

This unit is the on-chip data store of a small accumulator-style 8-bit controller. It holds 256 bytes of RAM and a 128-byte window of special-function storage. A single access port serves four access kinds. Register accesses pick one of eight working registers in the active bank. Direct accesses use an 8-bit address. Indirect accesses take their address from one of the first two working registers. Bit accesses use an 8-bit bit address. The unit works out from the access kind whether RAM or special-function storage is meant.

The active register bank comes from a two-bit field of a status byte that sits in the special-function window. Any write that reaches that byte, whether a byte write or a bit write, changes which bank the next register or indirect access uses. A bit write is done as a read-modify-write over two clocks. While the second clock is in progress, `busy` is high and the port does not accept an access. Reads return their byte on `rd_data`, and for bit reads the selected bit on `rd_bit`, one clock after they are accepted.

Top module: `idata_unit`

## Requirements
- R1: With `acc_mode` = 0 (register), `acc_addr[2:0]` selects working register n. It maps to RAM byte bank*8 + n, where bank is bits [4:3] of the status byte at special-function address 0xD0. A change of that field takes effect for the next accepted access.
- R2: With `acc_mode` = 1 (direct), addresses 0x00–0x7F reach RAM bytes 0x00–0x7F and addresses 0x80–0xFF reach special-function storage. The two spaces never alias.
- R3: With `acc_mode` = 2 (indirect), `acc_addr[0]` picks working register 0 or 1 of the active bank as a pointer, and the pointer addresses the full 256-byte RAM. Pointer values 0x80–0xFF reach the upper RAM and never special-function storage.
- R4: With `acc_mode` = 3 (bit), bit addresses 0x00–0x7F select bit addr[2:0] of RAM byte 0x20 + addr[6:3]. A bit read returns that bit on `rd_bit`.
- R5: Bit addresses 0x80–0xFF select bit addr[2:0] of special-function byte (addr & 0xF8).
- R6: After synchronous reset, all RAM and special-function bytes read as zero, `rd_data`, `rd_bit` and `busy` are zero, and bank 0 is active.
- R7: A bit write changes only the chosen bit of its byte. `busy` is high for exactly the one clock that follows the accepting edge, and the new value is visible to any access accepted after that.
- R8: An access presented while `busy` is high is ignored: it writes nothing and leaves `rd_data` unchanged.
- R9: `rd_data` and `rd_bit` are loaded at the edge that accepts a read and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_mode | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | 8 | Register number, byte address, pointer select or bit address |
| wr_data | input | 8 | Byte write data |
| bit_val | input | 1 | Value for a bit write |
| rd_data | output | 8 | Byte read result |
| rd_bit | output | 1 | Bit read result |
| busy | output | 1 | Second clock of a bit write; accesses ignored |

## Verification
A read presented before a rising edge is loaded on that edge. The bench therefore checks `rd_data` or `rd_bit` at the next falling edge. A bit write raises `busy` at the falling edge after its accepting edge, and the bench checks it there. `busy` must be low again one clock later, and the new byte is read back only after that. The bench drives the inputs on falling edges and samples the outputs on falling edges. In the bank, indirect and bit sweeps, every expected value comes from the bench's own byte model, and that model is updated only at the points where these latencies say the design has committed.

// File: rtl/idata_pkg.sv
package idata_pkg;

    localparam int DW          = 8;
    localparam int AW          = 8;
    localparam int RAM_DEPTH   = 256;
    localparam int SFR_DEPTH   = 128;
    localparam int SFR_AW      = $clog2(SFR_DEPTH);
    localparam int BANK_W      = 2;
    localparam int REG_IDX_W   = 3;
    localparam int BIT_IDX_W   = 3;
    localparam int BANK_LSB    = 3;
    localparam logic [AW-1:0]     BIT_RAM_BASE = 8'h20;
    localparam logic [SFR_AW-1:0] STAT_IDX     = 7'h50;

    typedef enum logic [1:0] {
        MODE_REG = 2'd0,
        MODE_DIR = 2'd1,
        MODE_IND = 2'd2,
        MODE_BIT = 2'd3
    } acc_mode_e;

    typedef struct packed {
        logic                 is_sfr;
        logic [AW-1:0]        addr;
        logic [BIT_IDX_W-1:0] bitpos;
    } target_t;

    function automatic logic [DW-1:0] bit_merge(
        input logic [DW-1:0]        byte_in,
        input logic [BIT_IDX_W-1:0] pos,
        input logic                 val
    );
        logic [DW-1:0] r;
        r      = byte_in;
        r[pos] = val;
        return r;
    endfunction

endpackage

// File: rtl/idata_ram.sv
module idata_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/idata_sfr.sv
module idata_sfr
    import idata_pkg::*;
#(
    parameter int DEPTH  = SFR_DEPTH,
    parameter int DW     = 8,
    parameter int BANKW  = BANK_W,
    parameter int BLSB   = BANK_LSB,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata,
    output logic [BANKW-1:0] bank
);

    logic [DW-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];
    assign bank  = regs[STAT_IDX][BLSB +: BANKW];

endmodule

// File: rtl/idata_decode.sv
module idata_decode
    import idata_pkg::*;
(
    input  acc_mode_e         mode,
    input  logic [AW-1:0]     addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [DW-1:0]     ptr_byte,
    output logic [AW-1:0]     ptr_addr,
    output target_t           tgt
);

    always_comb begin
        ptr_addr                        = '0;
        ptr_addr[REG_IDX_W +: BANK_W]   = bank;
        ptr_addr[0]                     = addr[0];
    end

    always_comb begin
        tgt = '0;
        unique case (mode)
            MODE_REG: begin
                tgt.addr[REG_IDX_W +: BANK_W] = bank;
                tgt.addr[REG_IDX_W-1:0]       = addr[REG_IDX_W-1:0];
            end
            MODE_DIR: begin
                tgt.is_sfr = addr[AW-1];
                tgt.addr   = addr;
            end
            MODE_IND: begin
                tgt.addr   = ptr_byte;
            end
            MODE_BIT: begin
                tgt.bitpos = addr[BIT_IDX_W-1:0];
                if (addr[AW-1]) begin
                    tgt.is_sfr = 1'b1;
                    tgt.addr   = {addr[AW-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};
                end else begin
                    tgt.addr   = BIT_RAM_BASE
                               + {{(BIT_IDX_W+1){1'b0}}, addr[AW-2:BIT_IDX_W]};
                end
            end
            default: tgt = '0;
        endcase
    end

endmodule

// File: rtl/idata_bitrmw.sv
module idata_bitrmw
    import idata_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  target_t       tgt,
    input  logic [DW-1:0] old_byte,
    input  logic          bit_val,
    output logic          busy,
    output logic          commit_sfr,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            commit_sfr  <= 1'b0;
            commit_addr <= '0;
            commit_data <= '0;
        end else begin
            busy <= start;
            if (start) begin
                commit_sfr  <= tgt.is_sfr;
                commit_addr <= tgt.addr;
                commit_data <= bit_merge(old_byte, tgt.bitpos, bit_val);
            end
        end
    end

endmodule

// File: rtl/idata_unit.sv
module idata_unit
    import idata_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_valid,
    input  logic [1:0] acc_mode,
    input  logic       acc_write,
    input  logic [7:0] acc_addr,
    input  logic [7:0] wr_data,
    input  logic       bit_val,
    output logic [7:0] rd_data,
    output logic       rd_bit,
    output logic       busy
);

    acc_mode_e         mode;
    target_t           tgt;
    logic [BANK_W-1:0] bank;
    logic [AW-1:0]     ptr_addr;
    logic [DW-1:0]     ptr_byte;
    logic [DW-1:0]     ram_byte;
    logic [DW-1:0]     sfr_byte;
    logic [DW-1:0]     cur_byte;
    logic              accept;
    logic              byte_we;
    logic              bit_start;
    logic              ram_we;
    logic              sfr_we;
    logic [AW-1:0]     wr_addr;
    logic [DW-1:0]     wr_byte;
    logic              commit_sfr;
    logic [AW-1:0]     commit_addr;
    logic [DW-1:0]     commit_data;

    assign mode      = acc_mode_e'(acc_mode);
    assign accept    = acc_valid && !busy;
    assign byte_we   = accept && acc_write && (mode != MODE_BIT);
    assign bit_start = accept && acc_write && (mode == MODE_BIT);

    idata_decode u_decode (
        .mode     (mode),
        .addr     (acc_addr),
        .bank     (bank),
        .ptr_byte (ptr_byte),
        .ptr_addr (ptr_addr),
        .tgt      (tgt)
    );

    assign cur_byte = tgt.is_sfr ? sfr_byte : ram_byte;

    idata_bitrmw u_rmw (
        .clk         (clk),
        .rst         (rst),
        .start       (bit_start),
        .tgt         (tgt),
        .old_byte    (cur_byte),
        .bit_val     (bit_val),
        .busy        (busy),
        .commit_sfr  (commit_sfr),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    assign wr_addr = busy ? commit_addr : tgt.addr;
    assign wr_byte = busy ? commit_data : wr_data;
    assign ram_we  = (byte_we && !tgt.is_sfr) || (busy && !commit_sfr);
    assign sfr_we  = (byte_we &&  tgt.is_sfr) || (busy &&  commit_sfr);

    idata_ram #(
        .DEPTH (RAM_DEPTH),
        .DW    (DW)
    ) u_ram (
        .clk     (clk),
        .rst     (rst),
        .we      (ram_we),
        .waddr   (wr_addr),
        .wdata   (wr_byte),
        .raddr_a (ptr_addr),
        .rdata_a (ptr_byte),
        .raddr_b (tgt.addr),
        .rdata_b (ram_byte)
    );

    idata_sfr #(
        .DEPTH (SFR_DEPTH),
        .DW    (DW),
        .BANKW (BANK_W),
        .BLSB  (BANK_LSB)
    ) u_sfr (
        .clk   (clk),
        .rst   (rst),
        .we    (sfr_we),
        .waddr (wr_addr[SFR_AW-1:0]),
        .wdata (wr_byte),
        .raddr (tgt.addr[SFR_AW-1:0]),
        .rdata (sfr_byte),
        .bank  (bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_bit  <= 1'b0;
        end else if (accept && !acc_write) begin
            rd_data <= cur_byte;
            rd_bit  <= cur_byte[tgt.bitpos];
        end
    end

endmodule

// File: rtl/idata_unit_chk.sv
module idata_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       accept,
    input logic       acc_write,
    input logic [1:0] acc_mode,
    input logic [7:0] acc_addr,
    input logic       bit_start,
    input logic       busy,
    input logic       sfr_we,
    input logic [1:0] bank,
    input logic [7:0] rd_data
);

    // R7
    bitwr_busy_chk: assert property (@(posedge clk) disable iff (rst)
        bit_start |=> busy);

    // R7
    busy_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rd_data));

    // R6
    reset_bank_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank == 2'd0));

    // R2
    dir_split_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && acc_write && acc_mode == 2'd1) |-> (sfr_we == acc_addr[7]));

    // R3
    indir_ram_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && acc_write && acc_mode == 2'd2) |-> !sfr_we);

    // R1
    bank_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank) |-> $past(sfr_we));

endmodule

bind idata_unit idata_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .acc_write (acc_write),
    .acc_mode  (acc_mode),
    .acc_addr  (acc_addr),
    .bit_start (bit_start),
    .busy      (busy),
    .sfr_we    (sfr_we),
    .bank      (bank),
    .rd_data   (rd_data)
);

// File: tb/idata_unit_tb_top.sv
module idata_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic [1:0] acc_mode  = 2'd0;
    logic       acc_write = 1'b0;
    logic [7:0] acc_addr  = 8'd0;
    logic [7:0] wr_data   = 8'd0;
    logic       bit_val   = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] ram_m [256];
    logic [7:0] sfr_m [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    idata_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_mode  (acc_mode),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .wr_data   (wr_data),
        .bit_val   (bit_val),
        .rd_data   (rd_data),
        .rd_bit    (rd_bit),
        .busy      (busy)
    );

    function automatic logic [1:0] bank_m();
        return sfr_m[7'h50][4:3];
    endfunction

    function automatic logic [7:0] get_b(input logic is_sfr, input logic [7:0] a);
        return is_sfr ? sfr_m[a[6:0]] : ram_m[a];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic w, input logic [7:0] a,
                         input logic [7:0] d, input logic b);
        @(negedge clk);
        acc_valid = 1'b1; acc_mode = m; acc_write = w;
        acc_addr  = a;    wr_data  = d; bit_val   = b;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wr_dir(input logic [7:0] a, input logic [7:0] d);
        drive(2'd1, 1'b1, a, d, 1'b0);
        if (a[7]) sfr_m[a[6:0]] = d; else ram_m[a] = d;
    endtask

    task automatic rd_dir(input string req, input logic [7:0] a);
        drive(2'd1, 1'b0, a, 8'd0, 1'b0);
        check(req, rd_data, get_b(a[7], a));
    endtask

    task automatic wr_reg(input logic [2:0] r, input logic [7:0] d);
        drive(2'd0, 1'b1, {5'd0, r}, d, 1'b0);
        ram_m[{3'd0, bank_m(), r}] = d;
    endtask

    task automatic rd_reg(input string req, input logic [2:0] r);
        drive(2'd0, 1'b0, {5'd0, r}, 8'd0, 1'b0);
        check(req, rd_data, ram_m[{3'd0, bank_m(), r}]);
    endtask

    task automatic wr_ind(input logic sel, input logic [7:0] d);
        drive(2'd2, 1'b1, {7'd0, sel}, d, 1'b0);
        ram_m[ram_m[{3'd0, bank_m(), 2'd0, sel}]] = d;
    endtask

    task automatic rd_ind(input string req, input logic sel);
        drive(2'd2, 1'b0, {7'd0, sel}, 8'd0, 1'b0);
        check(req, rd_data, ram_m[ram_m[{3'd0, bank_m(), 2'd0, sel}]]);
    endtask

    function automatic logic [7:0] bit_byte(input logic [7:0] ba);
        return ba[7] ? {ba[7:3], 3'b000} : (8'h20 + {4'd0, ba[6:3]});
    endfunction

    task automatic bit_wr(input logic [7:0] ba, input logic v);
        logic [7:0] loc;
        @(negedge clk);
        acc_valid = 1'b1; acc_mode = 2'd3; acc_write = 1'b1;
        acc_addr  = ba;   bit_val  = v;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R7 busy raised", {7'd0, busy}, 8'd1);
        @(negedge clk);
        check("R7 busy one clock", {7'd0, busy}, 8'd0);
        loc = bit_byte(ba);
        if (ba[7]) sfr_m[loc[6:0]][ba[2:0]] = v;
        else       ram_m[loc][ba[2:0]] = v;
    endtask

    task automatic bit_rd(input string req, input logic [7:0] ba);
        logic [7:0] loc;
        drive(2'd3, 1'b0, ba, 8'd0, 1'b0);
        loc = bit_byte(ba);
        check(req, {7'd0, rd_bit}, {7'd0, get_b(ba[7], loc)[ba[2:0]]});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        for (int i = 0; i < 256; i++) ram_m[i] = 8'd0;
        for (int i = 0; i < 128; i++) sfr_m[i] = 8'd0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6 reset state at the ports
        check("R6 rd_data", rd_data, 8'd0);
        check("R6 rd_bit", {7'd0, rd_bit}, 8'd0);
        check("R6 busy", {7'd0, busy}, 8'd0);
        for (int r = 0; r < 8; r++) rd_reg("R6 register zero", 3'(r));
        rd_dir("R6 status zero", 8'hD0);
        // R6 bank 0 active: register 5 lands at RAM 0x05
        wr_reg(3'd5, 8'hA5);
        drive(2'd1, 1'b0, 8'h05, 8'd0, 1'b0);
        check("R6 bank0 mapping", rd_data, 8'hA5);

        // R2 direct sweep of both spaces
        for (int a = 0; a < 128; a++) wr_dir(8'(a), 8'((a * 37 + 11) & 8'hFF));
        for (int a = 128; a < 256; a++) begin
            if (a == 8'hD0) wr_dir(8'(a), 8'h00);
            else            wr_dir(8'(a), 8'((a * 13 + 5) & 8'hFF));
        end
        for (int a = 0; a < 256; a++) rd_dir("R2 direct readback", 8'(a));

        // R1 every bank, every register
        for (int b = 0; b < 4; b++) begin
            wr_dir(8'hD0, 8'(b << 3));
            for (int r = 0; r < 8; r++) wr_reg(3'(r), 8'(8'h40 + b * 8 + r));
            for (int r = 0; r < 8; r++) begin
                rd_reg("R1 register readback", 3'(r));
                drive(2'd1, 1'b0, 8'(b * 8 + r), 8'd0, 1'b0);
                check("R1 bank mapping", rd_data, 8'(8'h40 + b * 8 + r));
            end
        end

        // R3 indirect through bank 2 pointers, upper RAM
        wr_dir(8'hD0, 8'h10);
        for (int a = 128; a < 256; a++) begin
            wr_reg(3'd0, 8'(a));
            wr_ind(1'b0, 8'(a ^ 8'h5A));
        end
        for (int a = 128; a < 256; a++) begin
            wr_reg(3'd1, 8'(a));
            rd_ind("R3 upper RAM via R1", 1'b1);
        end
        for (int a = 128; a < 256; a++) rd_dir("R3 SFR untouched", 8'(a));
        for (int a = 48; a < 64; a++) begin
            wr_reg(3'd0, 8'(a));
            wr_ind(1'b0, 8'(~a));
            rd_dir("R3 lower RAM via pointer", 8'(a));
        end

        // R4 / R5 all bit addresses: set, read, clear
        wr_dir(8'hD0, 8'h00);
        for (int ba = 0; ba < 256; ba++) begin
            bit_wr(8'(ba), 1'b1);
            rd_dir(ba < 128 ? "R4 byte after set" : "R5 byte after set", bit_byte(8'(ba)));
            bit_rd(ba < 128 ? "R4 bit read" : "R5 bit read", 8'(ba));
            bit_wr(8'(ba), 1'b0);
            rd_dir(ba < 128 ? "R4 byte after clear" : "R5 byte after clear", bit_byte(8'(ba)));
        end

        // R1 bank switched by bit writes on status bits 4 and 3
        bit_wr(8'hD4, 1'b1);
        bit_wr(8'hD3, 1'b1);
        wr_reg(3'd2, 8'hC3);
        drive(2'd1, 1'b0, 8'h1A, 8'd0, 1'b0);
        check("R1 bank3 via bit writes", rd_data, 8'hC3);

        // R9 hold after read
        rd_dir("R9 read", 8'h1A);
        held = rd_data;
        repeat (3) @(negedge clk);
        check("R9 hold", rd_data, held);

        // R8 access while busy is ignored
        @(negedge clk);
        acc_valid = 1'b1; acc_mode = 2'd3; acc_write = 1'b1;
        acc_addr  = 8'h05; bit_val = 1'b1;
        @(negedge clk);
        acc_mode = 2'd1; acc_write = 1'b1; acc_addr = 8'h41; wr_data = 8'hEE;
        check("R8 busy during ignore", {7'd0, busy}, 8'd1);
        @(negedge clk);
        acc_valid = 1'b0;
        ram_m[8'h20][5] = 1'b1;
        rd_dir("R8 write ignored", 8'h41);
        rd_dir("R7 bit set alongside", 8'h20);
        held = rd_data;
        @(negedge clk);
        acc_valid = 1'b1; acc_mode = 2'd3; acc_write = 1'b1;
        acc_addr  = 8'h06; bit_val = 1'b1;
        @(negedge clk);
        acc_mode = 2'd1; acc_write = 1'b0; acc_addr = 8'h30;
        @(negedge clk);
        acc_valid = 1'b0;
        ram_m[8'h20][6] = 1'b1;
        check("R8 read ignored", rd_data, held);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule